// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Guard

This block watches a decoded SDRAM command stream and keeps track, bank by bank, of whether a row is open and which row it is. It enforces three spacing rules measured in clock edges. The first is the delay from opening a row to the first read or write of that bank. The second is the spacing between two row openings of the same bank. The third is the spacing between row openings of any two different banks. The rules are set in nanoseconds. They are turned into clock counts at elaboration by dividing by the clock period and rounding up.

A controller consults the per-bank permission flags before it issues a command. If a command arrives that breaks a rule, the block ignores it for its own state tracking, raises a sticky violation flag and records the bank of the first offence. Refresh, mode programming, data handling and CAS latency are not part of this block.

Top module: `sdram_act_guard`

## Requirements
- R1: Each limit becomes a cycle count N = ceil(t_ns*1000/TCK_PS), with a minimum of 1. The defaults (TCK_PS=4000, TRCD_NS=10, TRC_NS=30, TRRD_NS=6) give 3 cycles for open-to-access, 8 for same-bank opening and 2 for cross-bank opening. A command gated by a limit is first legal on the N-th edge after the opening edge.
- R2: `may_act[b]` is high exactly when three conditions hold: bank b is closed, at least the same-bank count of edges separates the next edge from bank b's last accepted ACTIVE, and at least the cross-bank count separates it from the last accepted ACTIVE to any bank.
- R3: `may_rw[b]` is high exactly when bank b is open and at least the open-to-access count of edges separates the next edge from the ACTIVE that opened it.
- R4: An ACTIVE accepted while `may_act` is high for its bank opens that bank and stores its row. Bank b's row appears in `open_rows[12*b +: 12]` and its open state in `bank_open[b]`.
- R5: PRECHARGE closes the addressed bank. It does not restart the same-bank timer, so a new ACTIVE to that bank still waits out the same-bank count from the previous ACTIVE. A PRECHARGE to a closed bank has no effect and is not a violation.
- R6: A READ or WRITE to a bank whose `may_rw` is low sets `viol` and changes no bank state.
- R7: An ACTIVE to a bank whose `may_act` is low sets `viol`. It opens nothing, stores no row and restarts no timer.
- R8: `viol` stays high until reset, and `viol_bank` holds the bank of the first violating command.
- R9: A synchronous active-high reset closes all banks, clears the rows to zero, clears all timers (every `may_act` high, every `may_rw` low) and clears `viol` and `viol_bank`.
- R10: The command code is `cmd_in`: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE. Codes 5 to 7 act as NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_in | input | 3 | Command code for this edge |
| bank_in | input | 2 | Addressed bank |
| row_in | input | 12 | Row address used by ACTIVE |
| bank_open | output | 4 | One bit per bank, high while a row is open |
| open_rows | output | 48 | Stored row of each bank, 12 bits per bank |
| may_act | output | 4 | ACTIVE permitted on the next edge, per bank |
| may_rw | output | 4 | READ/WRITE permitted on the next edge, per bank |
| viol | output | 1 | Sticky rule-violation flag |
| viol_bank | output | 2 | Bank of the first violation |

## Verification
Each output is registered, so a command captured at one edge shows its effect on every output right after that edge. The permission flags reflect what is allowed on the following edge. The bench drives a command after a falling edge and compares all outputs at the next falling edge, before it drives the next command. Its reference model counts edges since each accepted ACTIVE. The same-bank, cross-bank and open-to-access sweeps vary the gap one cycle at a time across each limit, so that both the last illegal edge and the first legal edge are checked.

// File: rtl/act_guard_pkg.sv
package act_guard_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef struct packed {
        logic is_act;
        logic is_rw;
        logic is_pre;
    } cmd_dec_t;

    // ceiling of a nanosecond limit over the clock period, never below one
    function automatic int ns_to_cyc(input int t_ns, input int tck_ps);
        int c;
        c = (t_ns * 1000 + tck_ps - 1) / tck_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    // bits needed to hold values 0..n
    function automatic int cnt_bits(input int n);
        int w;
        w = 1;
        while ((1 << w) <= n) w++;
        return w;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    function automatic cmd_dec_t decode(input logic [2:0] code);
        cmd_dec_t d;
        d.is_act = (code == CMD_ACT);
        d.is_rw  = (code == CMD_RD) || (code == CMD_WR);
        d.is_pre = (code == CMD_PRE);
        return d;
    endfunction

endpackage

// File: rtl/act_guard_bank.sv
module act_guard_bank #(
    parameter int ROW_W = 12,
    parameter int CW = 4,
    parameter logic [CW-1:0] LD_RCD = '0,
    parameter logic [CW-1:0] LD_RC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_go,
    input  logic             pre_go,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] row_q,
    output logic             rcd_done,
    output logic             rc_done
);
    logic [CW-1:0] rcd_cnt;
    logic [CW-1:0] rc_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open <= 1'b0;
            row_q   <= '0;
            rcd_cnt <= '0;
            rc_cnt  <= '0;
        end else if (act_go) begin
            is_open <= 1'b1;
            row_q   <= row_in;
            rcd_cnt <= LD_RCD;
            rc_cnt  <= LD_RC;
        end else begin
            if (pre_go) is_open <= 1'b0;
            if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
            if (rc_cnt != '0) rc_cnt <= rc_cnt - 1'b1;
        end
    end

    assign rcd_done = (rcd_cnt == '0);
    assign rc_done  = (rc_cnt == '0);
endmodule

// File: rtl/act_guard_spacing.sv
module act_guard_spacing #(
    parameter int CW = 4,
    parameter logic [CW-1:0] LD = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= LD;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/act_guard_flag.sv
module act_guard_flag #(
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  logic [BW-1:0] hit_bank,
    output logic          viol,
    output logic [BW-1:0] viol_bank
);
    always_ff @(posedge clk) begin
        if (rst) begin
            viol      <= 1'b0;
            viol_bank <= '0;
        end else if (hit && !viol) begin
            viol      <= 1'b1;
            viol_bank <= hit_bank;
        end
    end
endmodule

// File: rtl/sdram_act_guard.sv
module sdram_act_guard
    import act_guard_pkg::*;
#(
    parameter int NBANKS = 4,
    parameter int ROW_W = 12,
    parameter int TCK_PS = 4000,
    parameter int TRCD_NS = 10,
    parameter int TRC_NS = 30,
    parameter int TRRD_NS = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [2:0]                cmd_in,
    input  logic [1:0]                bank_in,
    input  logic [ROW_W-1:0]          row_in,
    output logic [NBANKS-1:0]         bank_open,
    output logic [NBANKS*ROW_W-1:0]   open_rows,
    output logic [NBANKS-1:0]         may_act,
    output logic [NBANKS-1:0]         may_rw,
    output logic                      viol,
    output logic [1:0]                viol_bank
);
    localparam int NRCD = ns_to_cyc(TRCD_NS, TCK_PS);
    localparam int NRC  = ns_to_cyc(TRC_NS, TCK_PS);
    localparam int NRRD = ns_to_cyc(TRRD_NS, TCK_PS);
    localparam int CW   = cnt_bits(max3(NRCD, NRC, NRRD));
    localparam logic [CW-1:0] LD_RCD = CW'(NRCD - 1);
    localparam logic [CW-1:0] LD_RC  = CW'(NRC - 1);
    localparam logic [CW-1:0] LD_RRD = CW'(NRRD - 1);

    cmd_dec_t dec;
    logic act_ok, act_bad, rw_bad, act_take;
    logic rrd_done;
    logic [NBANKS-1:0] rcd_done, rc_done;

    assign dec      = decode(cmd_in);
    assign act_ok   = may_act[bank_in];
    assign act_take = dec.is_act && act_ok;
    assign act_bad  = dec.is_act && !act_ok;
    assign rw_bad   = dec.is_rw && !may_rw[bank_in];

    for (genvar i = 0; i < NBANKS; i++) begin : g_bank
        act_guard_bank #(
            .ROW_W(ROW_W), .CW(CW), .LD_RCD(LD_RCD), .LD_RC(LD_RC)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .act_go   (act_take && (bank_in == i)),
            .pre_go   (dec.is_pre && (bank_in == i)),
            .row_in   (row_in),
            .is_open  (bank_open[i]),
            .row_q    (open_rows[i*ROW_W +: ROW_W]),
            .rcd_done (rcd_done[i]),
            .rc_done  (rc_done[i])
        );
        assign may_act[i] = !bank_open[i] && rc_done[i] && rrd_done;
        assign may_rw[i]  = bank_open[i] && rcd_done[i];
    end

    act_guard_spacing #(.CW(CW), .LD(LD_RRD)) u_rrd (
        .clk  (clk),
        .rst  (rst),
        .load (act_take),
        .done (rrd_done)
    );

    act_guard_flag #(.BW(2)) u_flag (
        .clk       (clk),
        .rst       (rst),
        .hit       (act_bad || rw_bad),
        .hit_bank  (bank_in),
        .viol      (viol),
        .viol_bank (viol_bank)
    );
endmodule

// File: rtl/act_guard_chk.sv
module act_guard_chk
    import act_guard_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] cmd_in,
    input logic [1:0] bank_in,
    input logic [3:0] bank_open,
    input logic [3:0] may_act,
    input logic [3:0] may_rw,
    input logic       viol,
    input logic [1:0] viol_bank
);
    a_r6_bad_access: assert property (@(posedge clk) disable iff (rst)
        ((cmd_in == CMD_RD || cmd_in == CMD_WR) && !may_rw[bank_in]) |=> viol);

    a_r7_bad_activate: assert property (@(posedge clk) disable iff (rst)
        (cmd_in == CMD_ACT && !may_act[bank_in]) |=> viol);

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        viol |=> (viol && $stable(viol_bank)));

    a_r5_precharge_closes: assert property (@(posedge clk) disable iff (rst)
        (cmd_in == CMD_PRE) |=> !bank_open[$past(bank_in)]);

    a_r4_activate_opens: assert property (@(posedge clk) disable iff (rst)
        (cmd_in == CMD_ACT && may_act[bank_in]) |=>
            (bank_open[$past(bank_in)] && !may_act[$past(bank_in)]));

    a_r3_access_needs_open: assert property (@(posedge clk) disable iff (rst)
        ((may_rw & ~bank_open) == 4'b0000));
endmodule

bind sdram_act_guard act_guard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_in    (cmd_in),
    .bank_in   (bank_in),
    .bank_open (bank_open),
    .may_act   (may_act),
    .may_rw    (may_rw),
    .viol      (viol),
    .viol_bank (viol_bank)
);

// File: tb/sdram_act_guard_tb_top.sv
module sdram_act_guard_tb_top;
    localparam int N_RCD = 3;
    localparam int N_RC  = 8;
    localparam int N_RRD = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd_in = 3'd0;
    logic [1:0]  bank_in = 2'd0;
    logic [11:0] row_in = 12'd0;
    logic [3:0]  bank_open, may_act, may_rw;
    logic [47:0] open_rows;
    logic        viol;
    logic [1:0]  viol_bank;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    bit  m_open [4];
    int  m_row  [4];
    int  t_act  [4];
    int  t_any;
    int  edges;
    bit  m_viol;
    int  m_vbank;

    always #2 clk = ~clk;

    sdram_act_guard dut_i (
        .clk(clk), .rst(rst), .cmd_in(cmd_in), .bank_in(bank_in), .row_in(row_in),
        .bank_open(bank_open), .open_rows(open_rows), .may_act(may_act),
        .may_rw(may_rw), .viol(viol), .viol_bank(viol_bank)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (edge %0d)", req, act, exp, edges);
        end
    endtask

    function automatic bit exp_act(input int b);
        int cur;
        cur = edges + 1;
        return !m_open[b] && (cur - t_act[b] >= N_RC) && (cur - t_any >= N_RRD);
    endfunction

    function automatic bit exp_rw(input int b);
        return m_open[b] && (edges + 1 - t_act[b] >= N_RCD);
    endfunction

    task automatic check_outputs(input string tag);
        logic [3:0] ea, er, eo;
        logic [47:0] rows;
        for (int b = 0; b < 4; b++) begin
            ea[b] = exp_act(b);
            er[b] = exp_rw(b);
            eo[b] = m_open[b];
            rows[b*12 +: 12] = 12'(m_row[b]);
        end
        chk(may_act === ea, {"R1/R2 may_act ", tag}, 64'(may_act), 64'(ea));
        chk(may_rw === er, {"R1/R3 may_rw ", tag}, 64'(may_rw), 64'(er));
        chk(bank_open === eo, {"R4/R5 bank_open ", tag}, 64'(bank_open), 64'(eo));
        chk(open_rows === rows, {"R4 open_rows ", tag}, 64'(open_rows), 64'(rows));
        chk(viol === m_viol, {"R6/R7 viol ", tag}, 64'(viol), 64'(m_viol));
        chk(viol_bank === 2'(m_vbank), {"R8 viol_bank ", tag}, 64'(viol_bank), 64'(m_vbank));
    endtask

    task automatic model_flag(input int b);
        if (!m_viol) begin
            m_viol = 1;
            m_vbank = b;
        end
    endtask

    task automatic do_cmd(input int c, input int b, input int r, input string tag);
        @(negedge clk);
        check_outputs(tag);
        cmd_in = 3'(c);
        bank_in = 2'(b);
        row_in = 12'(r);
        @(posedge clk);
        // model: legality judged on the state before this edge
        case (c)
            1: if (exp_act(b)) begin
                   m_open[b] = 1; m_row[b] = r;
                   t_act[b] = edges + 1; t_any = edges + 1;
               end else model_flag(b);
            2, 3: if (!exp_rw(b)) model_flag(b);
            4: m_open[b] = 0;
            default: ;
        endcase
        edges++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        cmd_in = 3'd0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        for (int b = 0; b < 4; b++) begin
            m_open[b] = 0; m_row[b] = 0; t_act[b] = -100;
        end
        t_any = -100;
        m_viol = 0; m_vbank = 0; edges = 0;
    endtask

    function automatic int first_closed();
        for (int b = 0; b < 4; b++) if (!m_open[b]) return b;
        return 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        do_reset();
        do_cmd(0, 0, 0, "R9 reset state");

        // R2/R3: open-to-access and cross-bank spacing sweep, R8 second violation
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int g = 0; g < 6; g++) begin
                    do_reset();
                    do_cmd(1, a, a * 256 + g * 7 + 1, "open");
                    for (int k = 0; k < g; k++) do_cmd(0, a, 0, "gap");
                    if (a == b) do_cmd((g % 2) ? 3 : 2, a, 0, "R3 access after gap");
                    else        do_cmd(1, b, b * 256 + 5, "R2 cross-bank open");
                    do_cmd(0, 0, 0, "settle");
                    do_cmd(2, first_closed(), 0, "R6 read closed bank");
                    do_cmd(0, 0, 0, "R8 hold");
                end

        // R5/R7: same-bank re-open across precharge
        for (int a = 0; a < 4; a++)
            for (int g = 0; g < 7; g++) begin
                do_reset();
                do_cmd(1, a, 100 + a, "open");
                do_cmd(1, a, 200 + a, "R7 open while open");
                do_cmd(0, a, 0, "gap");
                do_cmd(4, a, 0, "R5 precharge");
                for (int k = 0; k < g; k++) do_cmd(0, a, 0, "gap");
                do_cmd(1, a, 300 + g, "R5 re-open");
                do_cmd(0, 0, 0, "settle");
                do_cmd(0, 0, 0, "settle");
            end

        // R10: undefined codes and precharge of a closed bank do nothing
        do_reset();
        do_cmd(1, 2, 77, "open");
        for (int c = 5; c < 8; c++) do_cmd(c, 1, 55, "R10 undefined code");
        do_cmd(4, 3, 0, "R5 precharge closed bank");
        do_cmd(2, 2, 0, "R3 legal read");
        do_cmd(0, 0, 0, "R10 final");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule